// File: doc/BRIEF.md
# Variable-Length PWM Counter with Pulse-Count Compare

This block is a 10-bit up/down counter whose active part can be cut to 4, 6, 8 or 10 low bits. A pulse-width modulated level toggles when the active field wraps and when the active field equals the low part of a compare value. The block therefore gives a PWM period of 16, 64, 256 or 1024 counter ticks, with the duty set by the compare value. The counter advances only on cycles where the clock enable is high. This lets a slow tick, or an external frequency, drive the period.

The compare interrupt has two modes. In limited mode it uses only the active bits, so the pulse train runs without end. In full mode it uses all ten bits. The bits above the active field act as a pulse counter, because every wrap of the field carries into them. When the whole counter equals the compare value, the interrupt fires and the counter stops. It stays stopped until the next load. The PWM level itself always follows the active-bit match, whichever mode is chosen.

Software-side details are not part of this block: register access, the prescaler and interrupt collection. The block only gives a load pulse, static controls and three outputs.

Top module: `pwm_lencmp`

## Requirements
- R1: `len_sel` picks the active length: 0 gives 10 bits, 1 gives 8 bits, 2 gives 6 bits and 3 gives 4 bits. The PWM period is therefore 1024, 256, 64 or 16 ticks.
- R2: When counting up, a wrap of the active field from all-ones to zero drives `pwm_out` to 1. An active-field match with `cmp_val` drives it to 0.
- R3: When counting down, a wrap of the active field from zero to all-ones drives `pwm_out` to 0. An active-field match drives it to 1.
- R4: The PWM match compares only the active bits, in either compare mode. If a wrap and a match fall on the same tick, the match level wins.
- R5: With `full_cmp`=0, `irq_cmp` fires on every active-field match and counting never stops.
- R6: With `full_cmp`=1, `irq_cmp` fires only when all ten counter bits equal `cmp_val`. The counter then stops, and outputs hold until the next load.
- R7: A wrap of the active field carries into the bits above it. These upper bits increment when counting up and decrement when counting down.
- R8: `mask_roll` suppresses `irq_roll` and `mask_cmp` suppresses `irq_cmp`. Neither mask changes the PWM level or the stop.
- R9: Each interrupt is a one-cycle pulse. It is visible in the cycle after the clock edge of the tick that caused it.
- R10: The counter advances only on edges where `run` and `cnt_en` are both 1. Otherwise the outputs hold and no interrupt fires.
- R11: `load` writes `load_val` into the counter and sets `pwm_out` to `dir_down`. It also clears a full-compare stop. A load takes priority over counting.
- R12: A compare value one step past the wrap gives a PWM pulse exactly one tick wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count tick enable |
| run | input | 1 | Counting allowed |
| dir_down | input | 1 | 1 = count down, 0 = count up |
| len_sel | input | 2 | Active length select |
| full_cmp | input | 1 | 1 = ten-bit compare with stop, 0 = active bits only |
| load | input | 1 | Load pulse |
| load_val | input | 10 | Initial counter value |
| cmp_val | input | 10 | Compare value |
| mask_roll | input | 1 | Suppress wrap interrupt |
| mask_cmp | input | 1 | Suppress compare interrupt |
| pwm_out | output | 1 | PWM level |
| irq_roll | output | 1 | Wrap interrupt pulse |
| irq_cmp | output | 1 | Compare interrupt pulse |

## Verification
The bench drives each scenario from a load for a fixed number of ticks. It then compares four tallies against the values worked out from the requirements:

- the number of wrap pulses;
- the number of compare pulses;
- the tick of the first wrap and of the last compare;
- the number of ticks with the PWM level high.

Runs at the 4-, 6-, 8- and 10-bit lengths tell the length decode apart. Up and down runs from non-zero starts separate the two polarities and the direction of the carry into the upper bits. A full-compare run with upper value 5 shows that limited-bit matches still move the PWM level but do not raise the interrupt, and that the counter stops after exactly five pulses. Mask, idle, disabled-tick and reload runs show that the suppressed or held state leaves the outputs untouched.

// File: rtl/pwm_lencmp.sv
module pwm_lencmp #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          run,
  input  logic          dir_down,
  input  logic [1:0]    len_sel,
  input  logic          full_cmp,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] cmp_val,
  input  logic          mask_roll,
  input  logic          mask_cmp,
  output logic          pwm_out,
  output logic          irq_roll,
  output logic          irq_cmp
);

  logic [CW-1:0] cnt, nxt, lmask;
  logic halted, pwm_q, irq_r, irq_c;
  logic advance, roll_ev, lmatch, fmatch, cmp_ev;

  assign lmask   = {CW{1'b1}} >> {len_sel, 1'b0};
  assign advance = run & cnt_en & ~halted & ~load;
  assign nxt     = dir_down ? cnt - 1'b1 : cnt + 1'b1;
  assign roll_ev = dir_down ? ((cnt & lmask) == '0) : ((cnt & lmask) == lmask);
  assign lmatch  = ((nxt ^ cmp_val) & lmask) == '0;
  assign fmatch  = nxt == cmp_val;
  assign cmp_ev  = full_cmp ? fmatch : lmatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      pwm_q  <= 1'b0;
      halted <= 1'b0;
      irq_r  <= 1'b0;
      irq_c  <= 1'b0;
    end else begin
      irq_r <= 1'b0;
      irq_c <= 1'b0;
      if (load) begin
        cnt    <= load_val;
        pwm_q  <= dir_down;
        halted <= 1'b0;
      end else if (advance) begin
        cnt <= nxt;
        if (lmatch)       pwm_q <= dir_down;
        else if (roll_ev) pwm_q <= ~dir_down;
        irq_r <= roll_ev & ~mask_roll;
        irq_c <= cmp_ev & ~mask_cmp;
        if (full_cmp && fmatch) halted <= 1'b1;
      end
    end
  end

  assign pwm_out  = pwm_q;
  assign irq_roll = irq_r;
  assign irq_cmp  = irq_c;

  AST_CMP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_c |=> !irq_c); // R9
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !load) |=> ($stable(cnt) && $stable(pwm_q) && !irq_r && !irq_c)); // R6
  AST_MASK_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    mask_roll |=> !irq_r); // R8
  AST_MASK_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    mask_cmp |=> !irq_c); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(run && cnt_en) && !load) |=> ($stable(cnt) && $stable(pwm_q) && !irq_r && !irq_c)); // R10
  AST_LOAD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (pwm_q == $past(dir_down) && cnt == $past(load_val) && !halted)); // R11

endmodule

// File: tb/sim_pwm_lencmp.sv
`timescale 1ns/1ps
module sim_pwm_lencmp;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cnt_en = 1'b0, run = 1'b0, dir_down = 1'b0, full_cmp = 1'b0, load = 1'b0;
  logic mask_roll = 1'b0, mask_cmp = 1'b0;
  logic [1:0] len_sel = 2'd3;
  logic [9:0] load_val = '0, cmp_val = '0;
  logic pwm_out, irq_roll, irq_cmp;

  int errors = 0, checks = 0;
  int nroll, ncmp, nhigh, first_roll, last_cmp, dbl;

  always #5 clk = ~clk;

  pwm_lencmp u0 (.clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .run(run), .dir_down(dir_down),
    .len_sel(len_sel), .full_cmp(full_cmp), .load(load), .load_val(load_val), .cmp_val(cmp_val),
    .mask_roll(mask_roll), .mask_cmp(mask_cmp), .pwm_out(pwm_out), .irq_roll(irq_roll),
    .irq_cmp(irq_cmp));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [9:0] v, input logic [9:0] c, input logic [1:0] s,
                         input logic f, input logic d);
    @(negedge clk);
    cnt_en = 1'b0; load_val = v; cmp_val = c; len_sel = s; full_cmp = f; dir_down = d;
    load = 1'b1; run = 1'b1;
    @(negedge clk);
    load = 1'b0;
    check(pwm_out == d, "R11 load level", int'(pwm_out), int'(d));
  endtask

  task automatic scan(input int n);
    logic prev_c;
    nroll = 0; ncmp = 0; nhigh = 0; first_roll = -1; last_cmp = -1; dbl = 0; prev_c = 1'b0;
    cnt_en = 1'b1;
    for (int s = 1; s <= n; s++) begin
      @(negedge clk);
      if (irq_roll) begin nroll++; if (first_roll < 0) first_roll = s; end
      if (irq_cmp) begin ncmp++; last_cmp = s; if (prev_c) dbl++; end
      prev_c = irq_cmp;
      if (pwm_out) nhigh++;
    end
    cnt_en = 1'b0;
  endtask

  task automatic t_reset();
    check(pwm_out == 1'b0 && !irq_roll && !irq_cmp, "R11 reset state",
          int'({pwm_out, irq_roll, irq_cmp}), 0);
  endtask

  task automatic t_up_limited();
    do_load(10'h000, 10'h052, 2'd3, 1'b0, 1'b0);
    scan(96);
    check(nroll == 6, "R2 up rolls len4", nroll, 6);
    check(first_roll == 16, "R1 4-bit period", first_roll, 16);
    check(ncmp == 6, "R5 limited compare unlimited", ncmp, 6);
    check(last_cmp == 82, "R5 last match tick", last_cmp, 82);
    check(nhigh == 11, "R2 up high ticks", nhigh, 11);
    check(dbl == 0, "R9 single-cycle pulse", dbl, 0);
  endtask

  task automatic t_up_full();
    do_load(10'h000, 10'h052, 2'd3, 1'b1, 1'b0);
    scan(100);
    check(nroll == 5, "R6 five pulses then stop", nroll, 5);
    check(ncmp == 1 && last_cmp == 82, "R6 full match tick", last_cmp, 82);
    check(nhigh == 10, "R4 pwm uses short match in full mode", nhigh, 10);
    check(pwm_out == 1'b0, "R6 level held after stop", int'(pwm_out), 0);
    scan(20);
    check(nroll == 0 && ncmp == 0, "R6 stopped counter silent", nroll + ncmp, 0);
    do_load(10'h000, 10'h052, 2'd3, 1'b1, 1'b0);
    scan(20);
    check(nroll == 1 && first_roll == 16, "R11 reload clears stop", first_roll, 16);
  endtask

  task automatic t_down_limited();
    do_load(10'h005, 10'h002, 2'd3, 1'b0, 1'b1);
    scan(40);
    check(nroll == 3 && first_roll == 6, "R3 down rolls", first_roll, 6);
    check(ncmp == 3 && last_cmp == 35, "R3 down matches", last_cmp, 35);
    check(nhigh == 11, "R3 down high ticks", nhigh, 11);
  endtask

  task automatic t_down_full();
    do_load(10'h030, 10'h01A, 2'd3, 1'b1, 1'b1);
    scan(30);
    check(nroll == 2, "R7 down carry rolls", nroll, 2);
    check(ncmp == 1 && last_cmp == 22, "R7 upper bits decrement to match", last_cmp, 22);
    check(nhigh == 20, "R3 down full high ticks", nhigh, 20);
  endtask

  task automatic t_lengths();
    do_load(10'h000, 10'h003, 2'd1, 1'b0, 1'b0);
    scan(300);
    check(nroll == 1 && first_roll == 256, "R1 8-bit period", first_roll, 256);
    check(ncmp == 2 && nhigh == 3, "R1 8-bit duty", nhigh, 3);
    do_load(10'h000, 10'h005, 2'd2, 1'b0, 1'b0);
    scan(140);
    check(nroll == 2 && first_roll == 64, "R1 6-bit period", first_roll, 64);
    check(ncmp == 3 && nhigh == 10, "R1 6-bit duty", nhigh, 10);
    do_load(10'h3F0, 10'h3F8, 2'd0, 1'b0, 1'b0);
    scan(30);
    check(nroll == 1 && first_roll == 16, "R1 10-bit wrap", first_roll, 16);
    check(ncmp == 1 && last_cmp == 8 && nhigh == 15, "R1 10-bit match", nhigh, 15);
  endtask

  task automatic t_carry_up();
    // len4 up, full compare 0x031 from 0x02E: wrap at tick 2 carries upper 2->3
    do_load(10'h02E, 10'h031, 2'd3, 1'b1, 1'b0);
    scan(10);
    check(nroll == 1 && ncmp == 1 && last_cmp == 3, "R7 up carry increments", last_cmp, 3);
  endtask

  task automatic t_masks();
    mask_roll = 1'b1; mask_cmp = 1'b1;
    do_load(10'h000, 10'h002, 2'd3, 1'b0, 1'b0);
    scan(40);
    check(nroll == 0 && ncmp == 0, "R8 masked interrupts", nroll + ncmp, 0);
    check(nhigh == 4, "R8 pwm unaffected by masks", nhigh, 4);
    mask_roll = 1'b0; mask_cmp = 1'b0;
  endtask

  task automatic t_hold();
    do_load(10'h000, 10'h002, 2'd3, 1'b0, 1'b0);
    run = 1'b0;
    scan(40);
    check(nroll == 0 && ncmp == 0 && nhigh == 0, "R10 run low holds", nroll + ncmp + nhigh, 0);
    run = 1'b1;
    repeat (40) @(negedge clk);
    check(!irq_roll && !irq_cmp && !pwm_out, "R10 enable low holds", int'(pwm_out), 0);
    scan(16);
    check(nroll == 1 && first_roll == 16, "R10 count resumes from held value", first_roll, 16);
  endtask

  task automatic t_min_width();
    do_load(10'h000, 10'h001, 2'd3, 1'b0, 1'b0);
    scan(40);
    check(nhigh == 2 && nroll == 2, "R12 one-tick pulse", nhigh, 2);
  endtask

  task automatic t_same_tick();
    do_load(10'h000, 10'h000, 2'd3, 1'b0, 1'b0);
    scan(40);
    check(nhigh == 0 && nroll == 2 && ncmp == 2, "R4 match wins over wrap", nhigh, 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_up_limited();
    t_up_full();
    t_down_limited();
    t_down_full();
    t_lengths();
    t_carry_up();
    t_masks();
    t_hold();
    t_min_width();
    t_same_tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule